// File: doc/BRIEF.md
# Paged Operand Stack with Service Interrupt

This block is an on-chip last-in-first-out operand store for a stack-oriented datapath. The pipeline pushes and pops through ready/valid handshakes and always sees the current top entry on a dedicated output. The block never moves data to or from main memory on its own. When a push meets a full stack, or a pop meets an empty one, the operation is held off and an interrupt is raised.

The service routine, or a DMA engine acting for it, then works through a small register port. It can start a page spill, which reads and removes a fixed number of the oldest entries, oldest first. It can also start a page fill, which writes a fixed number of entries in beneath the current bottom. The held pipeline operation then completes by itself. Storage is a circular buffer with a bottom pointer and a depth count, so entries can leave or enter at the bottom without any shifting. The page size is a parameter smaller than the stack depth.

Top module: `paged_stack`

## Requirements
- R1: After reset the depth is 0, `irq` is low, `top_valid` is low, no page operation is in progress, and `push_ready` is high while `push_valid` is high.
- R2: Pushed entries come back from pops in reverse order. `top_data` always shows the most recently pushed entry that has not been removed, and `top_valid` is high whenever the depth is non-zero.
- R3: A push against a full stack is not accepted (`push_ready` low) and leaves the stack contents unchanged. From the next cycle the overflow cause bit (status bit 8) is set and `irq` is high.
- R4: A pop against an empty stack is not accepted (`pop_ready` low). From the next cycle the underflow cause bit (status bit 9) is set and `irq` is high.
- R5: Writing address 1 with bit 0 set clears the overflow cause, and with bit 1 set clears the underflow cause. `irq` is the OR of the two cause bits. A condition that is still present in the same cycle sets its bit again.
- R6: Writing address 1 with bit 2 set starts a spill when no page operation is running and the depth is at least PAGE. Each read of address 2 with `reg_rd` high then returns the oldest entry and removes it. After PAGE such reads the operation ends. Status bit 10 is high while the operation runs.
- R7: Writing address 1 with bit 3 set starts a fill when no page operation is running and the depth is at most DEPTH-PAGE. Each write to address 2 then inserts its data beneath the current bottom. After PAGE writes the operation ends.
- R8: While a page operation runs, and in the cycle in which a page command is written, `push_ready` and `pop_ready` are low.
- R9: A push held against a full stack is not lost. It completes, with its data on top, once a spill has freed space and `push_valid` is still high.
- R10: When `push_valid` and `pop_valid` are high in the same cycle, only the push is accepted.
- R11: A read of address 0 returns the depth in bits 7:0, overflow in bit 8, underflow in bit 9 and page-busy in bit 10.
- R12: Reads and writes of address 2 outside a page operation do not change the depth or the contents.
- R13: A spill command with depth below PAGE, or a fill command with depth above DEPTH-PAGE, is ignored and no page operation starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Pipeline push request |
| push_data | input | WIDTH | Data to push |
| push_ready | output | 1 | Push accepted this cycle |
| pop_valid | input | 1 | Pipeline pop request |
| pop_ready | output | 1 | Pop accepted this cycle |
| top_data | output | WIDTH | Current top entry |
| top_valid | output | 1 | Stack is not empty |
| irq | output | 1 | Service interrupt |
| reg_addr | input | 2 | Register port address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (removes an entry during a spill) |
| reg_wdata | input | WIDTH | Register write data |
| reg_rdata | output | WIDTH | Register read data (combinational) |

## Verification
The hardest situation to reach is a pipeline push that stays held across a whole overflow service. The push is blocked at full, an interrupt is raised, the spill command is written, PAGE bottom reads are made, and only then is the held push accepted. The bench keeps `push_valid` high through that entire sequence and drives the register port alongside it. The scoreboard follows every accepted push, pop, spilled entry and filled entry, so it can show that the held item lands on top and that the spilled page comes out oldest first. The mirror case, a pop held across an underflow and a page fill, is driven the same way.

// File: rtl/pstk_pkg.sv
package pstk_pkg;
    localparam logic [1:0] A_STAT = 2'd0;
    localparam logic [1:0] A_CTRL = 2'd1;
    localparam logic [1:0] A_BOT  = 2'd2;

    localparam int B_ACK_OVF = 0;
    localparam int B_ACK_UNF = 1;
    localparam int B_SPILL   = 2;
    localparam int B_FILL    = 3;

    localparam int S_OVF  = 8;
    localparam int S_UNF  = 9;
    localparam int S_BUSY = 10;
endpackage

// File: rtl/pstk_mem.sv
module pstk_mem #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 32,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    widx,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    ridx_top,
    input  logic [AW-1:0]    ridx_bot,
    output logic [WIDTH-1:0] rdata_top,
    output logic [WIDTH-1:0] rdata_bot
);
    logic [WIDTH-1:0] cell_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cell_q[widx] <= wdata;
    end

    assign rdata_top = cell_q[ridx_top];
    assign rdata_bot = cell_q[ridx_bot];
endmodule

// File: rtl/pstk_ctrl.sv
module pstk_ctrl #(
    parameter int DEPTH = 32,
    parameter int PAGE  = 8,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(PAGE + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_valid,
    input  logic          pop_valid,
    input  logic          cmd_spill,
    input  logic          cmd_fill,
    input  logic          bot_rd,
    input  logic          bot_wr,
    output logic          push_ready,
    output logic          pop_ready,
    output logic          blk_ovf,
    output logic          blk_unf,
    output logic [AW:0]   depth,
    output logic          busy,
    output logic [AW-1:0] bot_idx,
    output logic [AW-1:0] top_idx,
    output logic          wr_en,
    output logic          wr_fill,
    output logic [AW-1:0] wr_idx
);
    localparam logic [AW:0] FULL_LV  = (AW+1)'(DEPTH);
    localparam logic [AW:0] PAGE_LV  = (AW+1)'(PAGE);
    localparam logic [AW:0] ROOM_LV  = (AW+1)'(DEPTH - PAGE);
    localparam logic [CW-1:0] PAGE_CNT = CW'(PAGE);

    typedef struct packed {
        logic [AW-1:0] bot;
        logic [AW:0]   depth;
        logic          busy;
        logic          fill;
        logic [CW-1:0] left;
    } ctrl_t;

    ctrl_t st_q, st_d;
    logic full, empty, cmd_any, spill_step, fill_step, push_fire, pop_fire;

    always_comb begin
        st_d       = st_q;
        full       = (st_q.depth == FULL_LV);
        empty      = (st_q.depth == '0);
        cmd_any    = cmd_spill | cmd_fill;
        push_ready = !st_q.busy && !full && !cmd_any;
        pop_ready  = !st_q.busy && !empty && !cmd_any && !push_valid;
        push_fire  = push_valid && push_ready;
        pop_fire   = pop_valid && pop_ready;
        blk_ovf    = push_valid && full && !st_q.busy;
        blk_unf    = pop_valid && empty && !push_valid && !st_q.busy;
        spill_step = st_q.busy && !st_q.fill && bot_rd;
        fill_step  = st_q.busy && st_q.fill && bot_wr;
        wr_en      = push_fire || fill_step;
        wr_fill    = fill_step;
        wr_idx     = fill_step ? st_q.bot - 1'b1 : st_q.bot + st_q.depth[AW-1:0];

        if (push_fire) begin
            st_d.depth = st_q.depth + 1'b1;
        end else if (pop_fire) begin
            st_d.depth = st_q.depth - 1'b1;
        end

        if (spill_step || fill_step) begin
            st_d.left = st_q.left - 1'b1;
            if (st_q.left == CW'(1)) st_d.busy = 1'b0;
            if (spill_step) begin
                st_d.bot   = st_q.bot + 1'b1;
                st_d.depth = st_q.depth - 1'b1;
            end else begin
                st_d.bot   = st_q.bot - 1'b1;
                st_d.depth = st_q.depth + 1'b1;
            end
        end

        if (!st_q.busy) begin
            if (cmd_spill && st_q.depth >= PAGE_LV) begin
                st_d.busy = 1'b1;
                st_d.fill = 1'b0;
                st_d.left = PAGE_CNT;
            end else if (cmd_fill && !cmd_spill && st_q.depth <= ROOM_LV) begin
                st_d.busy = 1'b1;
                st_d.fill = 1'b1;
                st_d.left = PAGE_CNT;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign depth   = st_q.depth;
    assign busy    = st_q.busy;
    assign bot_idx = st_q.bot;
    assign top_idx = st_q.bot + st_q.depth[AW-1:0] - 1'b1;

    a_r3_no_push_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        (depth == FULL_LV) |-> !push_ready);
    a_r4_no_pop_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (depth == '0) |-> !pop_ready);
    a_r8_busy_blocks_pipe: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!push_ready && !pop_ready));
    a_r10_push_wins: assert property (@(posedge clk) disable iff (!rst_n)
        push_valid |-> !pop_ready);
    a_r6_spill_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bot_rd && !$past(cmd_any) && !wr_fill && !bot_wr && !st_q.fill)
        |=> (depth == $past(depth) - 1'b1));
    a_r2_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
        depth <= FULL_LV);
endmodule

// File: rtl/pstk_irq.sv
module pstk_irq (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_ovf,
    input  logic       set_unf,
    input  logic       clr_ovf,
    input  logic       clr_unf,
    output logic [1:0] cause,
    output logic       irq
);
    typedef struct packed {
        logic ovf;
        logic unf;
    } cause_t;

    cause_t c_q, c_d;

    always_comb begin
        c_d = c_q;
        if (clr_ovf) c_d.ovf = 1'b0;
        if (clr_unf) c_d.unf = 1'b0;
        if (set_ovf) c_d.ovf = 1'b1;
        if (set_unf) c_d.unf = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign cause = {c_q.unf, c_q.ovf};
    assign irq   = c_q.ovf | c_q.unf;

    a_r3_ovf_latches: assert property (@(posedge clk) disable iff (!rst_n)
        set_ovf |=> cause[0]);
    a_r4_unf_latches: assert property (@(posedge clk) disable iff (!rst_n)
        set_unf |=> cause[1]);
    a_r5_ack_clears_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_ovf && !set_ovf) |=> !cause[0]);
    a_r5_ack_clears_unf: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_unf && !set_unf) |=> !cause[1]);
endmodule

// File: rtl/paged_stack.sv
module paged_stack
    import pstk_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int DEPTH = 32,
    parameter int PAGE  = 8,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_valid,
    input  logic [WIDTH-1:0] push_data,
    output logic             push_ready,
    input  logic             pop_valid,
    output logic             pop_ready,
    output logic [WIDTH-1:0] top_data,
    output logic             top_valid,
    output logic             irq,
    input  logic [1:0]       reg_addr,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [WIDTH-1:0] reg_wdata,
    output logic [WIDTH-1:0] reg_rdata
);
    logic ctrl_wr, bot_rd, bot_wr, cmd_spill, cmd_fill, ack_ovf, ack_unf;
    logic blk_ovf, blk_unf, busy, wr_en, wr_fill;
    logic [AW:0]   depth;
    logic [AW-1:0] bot_idx, top_idx, wr_idx;
    logic [1:0]    cause;
    logic [WIDTH-1:0] bot_data, wr_data;

    assign ctrl_wr   = reg_wr && (reg_addr == A_CTRL);
    assign cmd_spill = ctrl_wr && reg_wdata[B_SPILL];
    assign cmd_fill  = ctrl_wr && reg_wdata[B_FILL];
    assign ack_ovf   = ctrl_wr && reg_wdata[B_ACK_OVF];
    assign ack_unf   = ctrl_wr && reg_wdata[B_ACK_UNF];
    assign bot_rd    = reg_rd && (reg_addr == A_BOT);
    assign bot_wr    = reg_wr && (reg_addr == A_BOT);

    pstk_ctrl #(.DEPTH(DEPTH), .PAGE(PAGE)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .push_valid(push_valid), .pop_valid(pop_valid),
        .cmd_spill(cmd_spill), .cmd_fill(cmd_fill),
        .bot_rd(bot_rd), .bot_wr(bot_wr),
        .push_ready(push_ready), .pop_ready(pop_ready),
        .blk_ovf(blk_ovf), .blk_unf(blk_unf),
        .depth(depth), .busy(busy),
        .bot_idx(bot_idx), .top_idx(top_idx),
        .wr_en(wr_en), .wr_fill(wr_fill), .wr_idx(wr_idx)
    );

    assign wr_data = wr_fill ? reg_wdata : push_data;

    pstk_mem #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_mem (
        .clk(clk), .we(wr_en), .widx(wr_idx), .wdata(wr_data),
        .ridx_top(top_idx), .ridx_bot(bot_idx),
        .rdata_top(top_data), .rdata_bot(bot_data)
    );

    pstk_irq u_irq (
        .clk(clk), .rst_n(rst_n),
        .set_ovf(blk_ovf), .set_unf(blk_unf),
        .clr_ovf(ack_ovf), .clr_unf(ack_unf),
        .cause(cause), .irq(irq)
    );

    assign top_valid = (depth != '0);

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_STAT: begin
                reg_rdata[AW:0]   = depth;
                reg_rdata[S_OVF]  = cause[0];
                reg_rdata[S_UNF]  = cause[1];
                reg_rdata[S_BUSY] = busy;
            end
            A_BOT:   reg_rdata = bot_data;
            default: reg_rdata = '0;
        endcase
    end

    a_r2_top_valid_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && push_ready) |=> top_valid);
    a_r9_held_push_waits: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && !push_ready && cause[0]) |-> !(pop_valid && pop_ready));
endmodule

// File: tb/paged_stack_tb.sv
module paged_stack_tb;
    localparam int W = 16;
    localparam int D = 8;
    localparam int P = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic push_valid = 1'b0, pop_valid = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0;
    logic [W-1:0] push_data = '0, reg_wdata = '0;
    logic [1:0] reg_addr = '0;
    logic push_ready, pop_ready, top_valid, irq;
    logic [W-1:0] top_data, reg_rdata;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;
    int page_mode = 0;
    logic [W-1:0] expq [$];
    logic [W-1:0] v;

    always #2 clk = ~clk;

    paged_stack #(.WIDTH(W), .DEPTH(D), .PAGE(P)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .push_valid(push_valid), .push_data(push_data), .push_ready(push_ready),
        .pop_valid(pop_valid), .pop_ready(pop_ready),
        .top_data(top_data), .top_valid(top_valid), .irq(irq),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // scoreboard monitor: follows every accepted transfer, compares outgoing data
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            if (push_valid && push_ready) begin
                expq.push_back(push_data);
            end else if (pop_valid && pop_ready) begin
                if (expq.size() == 0) chk(1'b0, "R2 pop from empty model", int'(top_data), 0);
                else begin
                    chk(top_data == expq[$], "R2 popped data", int'(top_data), int'(expq[$]));
                    void'(expq.pop_back());
                end
            end
            if (reg_rd && reg_addr == 2'd2 && page_mode == 1) begin
                chk(reg_rdata == expq[0], "R6 spilled oldest first", int'(reg_rdata), int'(expq[0]));
                void'(expq.pop_front());
            end
            if (reg_wr && reg_addr == 2'd2 && page_mode == 2) expq.push_front(reg_wdata);
        end
    end

    task automatic push(input logic [W-1:0] d);
        @(negedge clk);
        push_valid = 1'b1; push_data = d;
        #1 chk(push_ready, "R2 push accepted", int'(push_ready), 1);
        @(posedge clk); #1 push_valid = 1'b0;
    endtask

    task automatic pop();
        @(negedge clk);
        pop_valid = 1'b1;
        #1 chk(pop_ready, "R2 pop accepted", int'(pop_ready), 1);
        @(posedge clk); #1 pop_valid = 1'b0;
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [W-1:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk); #1 reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, input bit strobe, output logic [W-1:0] r);
        @(negedge clk);
        reg_addr = a; reg_rd = strobe;
        #1 r = reg_rdata;
        @(posedge clk); #1 reg_rd = 1'b0;
    endtask

    task automatic chk_depth(input string req);
        logic [W-1:0] s;
        reg_read(2'd0, 1'b0, s);
        chk(int'(s[7:0]) == expq.size(), req, int'(s[7:0]), expq.size());
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog expired (all requirements) actual=0 expected=1");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        @(negedge clk); #1;
        chk(!irq, "R1 irq low", int'(irq), 0);
        chk(!top_valid, "R1 top_valid low", int'(top_valid), 0);
        reg_read(2'd0, 1'b0, v);
        chk(v == '0, "R1 R11 status zero", int'(v), 0);

        // R4 pop on empty is held and raises underflow
        @(negedge clk); pop_valid = 1'b1;
        #1 chk(!pop_ready, "R4 pop refused on empty", int'(pop_ready), 0);
        @(posedge clk); #1 pop_valid = 1'b0;
        @(negedge clk); #1 chk(irq, "R4 irq raised", int'(irq), 1);
        reg_read(2'd0, 1'b0, v);
        chk(v[9] == 1'b1, "R4 R11 underflow bit", int'(v), 32'h200);
        reg_write(2'd1, 16'h0002);
        @(negedge clk); #1 chk(!irq, "R5 ack clears irq", int'(irq), 0);

        // R2 LIFO order
        push(16'h0010); push(16'h0011); push(16'h0012);
        @(negedge clk); #1;
        chk(top_valid, "R2 top_valid", int'(top_valid), 1);
        chk(top_data == 16'h0012, "R2 top shows newest", int'(top_data), 16'h12);
        chk_depth("R11 depth field 3");
        pop();

        // R10 push wins over simultaneous pop
        @(negedge clk); push_valid = 1'b1; push_data = 16'h0013; pop_valid = 1'b1;
        #1 chk(!pop_ready && push_ready, "R10 only push accepted", int'({push_ready, pop_ready}), 2);
        @(posedge clk); #1 begin push_valid = 1'b0; pop_valid = 1'b0; end
        @(negedge clk); #1 chk(top_data == 16'h0013, "R10 pushed item on top", int'(top_data), 16'h13);

        // R12 bottom access outside a page operation
        reg_read(2'd2, 1'b1, v);
        chk(v == 16'h0010, "R12 bottom peek", int'(v), 16'h10);
        reg_write(2'd2, 16'hdead);
        chk_depth("R12 depth unchanged");
        @(negedge clk); #1 chk(top_data == 16'h0013, "R12 top unchanged", int'(top_data), 16'h13);

        // R13 spill refused below PAGE
        reg_write(2'd1, 16'h0004);
        reg_read(2'd0, 1'b0, v);
        chk(v[10] == 1'b0, "R13 spill refused", int'(v[10]), 0);

        // fill to full
        for (int i = 0; i < 5; i++) push(16'h0020 + 16'(i));
        chk_depth("R2 depth full");

        // R3 overflow, push held
        @(negedge clk); push_valid = 1'b1; push_data = 16'h0099;
        #1 chk(!push_ready, "R3 push refused on full", int'(push_ready), 0);
        @(posedge clk);
        @(negedge clk); #1;
        chk(irq, "R3 irq raised", int'(irq), 1);
        chk(top_data == 16'h0024, "R3 top unchanged", int'(top_data), 16'h24);
        reg_read(2'd0, 1'b0, v);
        chk(v[8] == 1'b1 && v[7:0] == 8'd8, "R3 R11 overflow bit and depth", int'(v), 32'h108);

        // R6 spill one page while push stays held
        page_mode = 1;
        @(negedge clk); reg_addr = 2'd1; reg_wdata = 16'h0004; reg_wr = 1'b1;
        #1 chk(!push_ready, "R8 blocked in command cycle", int'(push_ready), 0);
        @(posedge clk); #1 reg_wr = 1'b0;
        @(negedge clk); reg_addr = 2'd0;
        #1 begin
            chk(reg_rdata[10], "R6 busy bit set", int'(reg_rdata[10]), 1);
            chk(!push_ready, "R8 push blocked while busy", int'(push_ready), 0);
        end
        for (int i = 0; i < P; i++) reg_read(2'd2, 1'b1, v);
        page_mode = 0;

        // R9 held push completes
        @(negedge clk);
        #1 chk(push_ready, "R9 held push accepted", int'(push_ready), 1);
        @(posedge clk); #1 push_valid = 1'b0;
        @(negedge clk); #1 chk(top_data == 16'h0099, "R9 held data on top", int'(top_data), 16'h99);
        reg_read(2'd0, 1'b0, v);
        chk(v[10] == 1'b0, "R6 busy clears after page", int'(v[10]), 0);
        chk_depth("R6 depth after spill");
        reg_write(2'd1, 16'h0001);
        @(negedge clk); #1 chk(!irq, "R5 overflow ack", int'(irq), 0);

        // drain
        for (int i = 0; i < 5; i++) pop();
        chk_depth("R2 drained");

        // R7 fill a page under a held pop
        @(negedge clk); pop_valid = 1'b1;
        @(posedge clk);
        @(negedge clk); #1 chk(irq, "R4 underflow with held pop", int'(irq), 1);
        reg_write(2'd1, 16'h0008);
        page_mode = 2;
        reg_write(2'd2, 16'h0020);
        reg_write(2'd2, 16'h0013);
        reg_write(2'd2, 16'h0011);
        reg_write(2'd2, 16'h0010);
        page_mode = 0;
        @(negedge clk);
        #1 chk(pop_ready, "R7 held pop proceeds after fill", int'(pop_ready), 1);
        @(posedge clk); #1 pop_valid = 1'b0;
        chk_depth("R7 depth after fill and pop");
        for (int i = 0; i < 3; i++) pop();
        reg_write(2'd1, 16'h0002);
        @(negedge clk); #1 chk(!top_valid && !irq, "R7 empty after restore", int'({top_valid, irq}), 0);

        // R13 fill refused above DEPTH-PAGE
        for (int i = 0; i < 5; i++) push(16'h0040 + 16'(i));
        reg_write(2'd1, 16'h0008);
        reg_read(2'd0, 1'b0, v);
        chk(v[10] == 1'b0, "R13 fill refused", int'(v[10]), 0);
        chk(v[7:0] == 8'd5, "R13 depth kept", int'(v[7:0]), 5);
        for (int i = 0; i < 5; i++) pop();

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule